// File: doc/BRIEF.md
# Infrared Transmit Carrier Modulator

This block shapes the serial transmit bit stream of a UART before it reaches an infrared LED pin. The data bit can first be inverted. When modulation is on, every zero bit is replaced by a square carrier with a programmable low fraction. Every one bit stays a steady high level. A four-way source selector then decides what drives the pin: the shaped UART stream, a general-purpose output bit, or one of two energy-metering pulse trains (watt or var). The selected value is registered once before it leaves the block.

The carrier comes from a small counter that advances only on a carrier-rate tick supplied from outside, so the carrier frequency is set by the tick rate. The counter is forced back to zero at the first cycle of each zero bit. Each modulated bit therefore starts with a whole carrier period that begins in its low phase.

Top module: `irtx_carrier_mod`

## Requirements
- R1: While reset is asserted, and after it is released with all control inputs at 0, `pin_out` is 1. With all controls at 0, `pin_out` equals `tx_raw` from the previous clock edge.
- R2: When `cfg_invert` is 1, the data bit is flipped before modulation. With `cfg_invert`=1 and `cfg_mod_en`=1, a raw 1 produces the carrier and a raw 0 produces a steady high level.
- R3: When `cfg_mod_en` is 0 and the UART path is selected, `pin_out` equals the post-inversion data bit one clock later.
- R4: When `cfg_mod_en` is 1, a post-inversion 1 drives `pin_out` high for every cycle, whatever the tick or carrier state.
- R5: For a post-inversion 0 with modulation on, the carrier is low for the first L counts of each 16-count period and high for the rest. L is 8, 4, 2 or 1 for `cfg_duty` = 00, 01, 10, 11 respectively.
- R6: The carrier count advances by one only in cycles where `car_tick` is 1. Without ticks, the carrier phase holds.
- R7: The carrier count restarts at 0 in the first cycle of each zero bit, which is a cycle whose post-inversion data is 0 after a cycle in which it was 1.
- R8: `cfg_pin_sel` picks the source of the pin: 00 the UART path, 01 `gpo_val`, 10 `wpulse_in`, 11 `rpulse_in`. The chosen value appears on `pin_out` one clock later.
- R9: A change of any configuration input is reflected in `pin_out` one clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_raw | input | 1 | Raw UART transmit bit |
| car_tick | input | 1 | Carrier-rate advance enable, one cycle wide |
| cfg_invert | input | 1 | Invert data before modulation |
| cfg_mod_en | input | 1 | Enable carrier on zero bits |
| cfg_duty | input | 2 | Carrier low fraction select |
| cfg_pin_sel | input | 2 | Pin source select |
| gpo_val | input | 1 | General-purpose output level |
| wpulse_in | input | 1 | Watt energy pulse |
| rpulse_in | input | 1 | Var energy pulse |
| pin_out | output | 1 | Registered LED pin drive |

## Verification
The bench plays long zero bits at every duty setting and at two tick rates, and checks that the carrier wraps after 16 counts. A design that decodes the duty field wrongly would show the wrong number of low cycles. A design that counts every clock instead of every tick would run the carrier too fast. A short zero bit followed by a single high cycle and another zero bit checks the restart: a counter that carries on would begin the second bit in its high phase. Inversion together with modulation checks the order of the two operations, because modulating first and inverting afterwards would put the carrier on the ones. Source switching checks each select code and its one-cycle latency.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
   typedef enum logic [1:0] {
      PIN_UART = 2'b00,
      PIN_GPO  = 2'b01,
      PIN_WATT = 2'b10,
      PIN_VAR  = 2'b11
   } pin_src_e;

   // number of low counts in one carrier period for a duty code
   function automatic int unsigned low_counts(input int unsigned cnt_w,
                                              input int unsigned duty);
      return (1 << (cnt_w - 1)) >> duty;
   endfunction
endpackage

// File: rtl/irtx_carrier_gen.sv
module irtx_carrier_gen #(
   parameter int CNT_W  = 4,
   parameter int DUTY_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_bit,
   input  logic              tick,
   input  logic [DUTY_W-1:0] duty,
   output logic              low_phase,
   output logic              zero_start
);
   localparam int THR_W = CNT_W + 1;

   if (CNT_W < (1 << DUTY_W)) begin : g_bad_width
      $error("CNT_W too small for the shortest low phase");
   end

   logic             data_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_eff;
   logic [THR_W-1:0] thr;

   assign zero_start = data_q & ~data_bit;
   assign cnt_eff    = zero_start ? '0 : cnt_q;
   assign thr        = THR_W'(irtx_pkg::low_counts(CNT_W, int'(duty)));
   assign low_phase  = ({1'b0, cnt_eff} < thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= 1'b1;
         cnt_q  <= '0;
      end else begin
         data_q <= data_bit;
         if (tick) cnt_q <= cnt_eff + CNT_W'(1);
         else      cnt_q <= cnt_eff;
      end
   end

   // R6: phase holds without a tick
   a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !zero_start) |=> cnt_q == $past(cnt_q));
   // R7: a fresh zero bit always opens in the low phase
   a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      zero_start |-> low_phase);
endmodule

// File: rtl/irtx_tx_shaper.sv
module irtx_tx_shaper (
   input  logic tx_raw,
   input  logic invert,
   input  logic mod_en,
   input  logic low_phase,
   output logic data_bit,
   output logic shaped
);
   assign data_bit = tx_raw ^ invert;
   assign shaped   = data_bit | (mod_en & ~low_phase);
endmodule

// File: rtl/irtx_pin_select.sv
module irtx_pin_select #(
   parameter int  SEL_W   = 2,
   parameter bit  OUT_REG = 1'b1,
   parameter bit  RST_VAL = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SEL_W-1:0]      sel,
   input  logic [(1<<SEL_W)-1:0] srcs,
   output logic                  pin
);
   logic pin_next;
   assign pin_next = srcs[sel];

   if (OUT_REG) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= RST_VAL;
         else        pin_q <= pin_next;
      end
      assign pin = pin_q;
   end else begin : g_comb
      assign pin = pin_next;
   end
endmodule

// File: rtl/irtx_carrier_mod.sv
module irtx_carrier_mod #(
   parameter int CNT_W   = 4,
   parameter int DUTY_W  = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_raw,
   input  logic              car_tick,
   input  logic              cfg_invert,
   input  logic              cfg_mod_en,
   input  logic [DUTY_W-1:0] cfg_duty,
   input  logic [1:0]        cfg_pin_sel,
   input  logic              gpo_val,
   input  logic              wpulse_in,
   input  logic              rpulse_in,
   output logic              pin_out
);
   import irtx_pkg::*;

   logic       data_bit, shaped, low_phase, zero_start;
   logic [3:0] srcs;

   irtx_tx_shaper u_shaper (
      .tx_raw   (tx_raw),
      .invert   (cfg_invert),
      .mod_en   (cfg_mod_en),
      .low_phase(low_phase),
      .data_bit (data_bit),
      .shaped   (shaped)
   );

   irtx_carrier_gen #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_carrier (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_bit  (data_bit),
      .tick      (car_tick),
      .duty      (cfg_duty),
      .low_phase (low_phase),
      .zero_start(zero_start)
   );

   always_comb begin
      srcs           = '0;
      srcs[PIN_UART] = shaped;
      srcs[PIN_GPO]  = gpo_val;
      srcs[PIN_WATT] = wpulse_in;
      srcs[PIN_VAR]  = rpulse_in;
   end

   irtx_pin_select #(.SEL_W(2), .OUT_REG(OUT_REG), .RST_VAL(1'b1)) u_sel (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (cfg_pin_sel),
      .srcs (srcs),
      .pin  (pin_out)
   );

   if (OUT_REG) begin : g_chk
      // R4: a one bit on the UART path never shows a low
      a_r4_one_high: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_pin_sel == PIN_UART && data_bit) |=> pin_out);
      // R3: unmodulated path follows the post-inversion data
      a_r3_plain: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_pin_sel == PIN_UART && !cfg_mod_en) |=> pin_out == $past(data_bit));
      // R8: general-purpose source reaches the pin
      a_r8_gpo: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_pin_sel == PIN_GPO) |=> pin_out == $past(gpo_val));
      // R5: zero bit during the low phase drives the pin low
      a_r5_low: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_pin_sel == PIN_UART && !data_bit && low_phase) |=> !pin_out);
   end
endmodule

// File: tb/test_irtx_carrier_mod.sv
module test_irtx_carrier_mod;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_raw = 1'b1, car_tick = 1'b0, cfg_invert = 1'b0, cfg_mod_en = 1'b0;
   logic [1:0] cfg_duty = 2'b00, cfg_pin_sel = 2'b00;
   logic gpo_val = 1'b0, wpulse_in = 1'b0, rpulse_in = 1'b0;
   logic pin_out;
   int vectors = 0, miscompares = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   irtx_carrier_mod i_irtx_carrier_mod (.*);

   task automatic check(input logic exp, input string req, input string what);
      vectors++;
      if (pin_out !== exp) begin
         miscompares++;
         $display("FAIL %s %s: pin_out=%b expected %b at %0t", req, what, pin_out, exp, $time);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   // R1: reset value and plain path
   task automatic t_reset();
      @(negedge clk);
      check(1'b1, "R1", "during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check(1'b1, "R1", "after reset idle");
      for (int i = 0; i < 8; i++) begin
         tx_raw = logic'((i * 5 + 1) % 3 == 0);
         @(negedge clk);
         check(tx_raw, "R1", "plain follow");
      end
   endtask

   // R3/R2: unmodulated path, plain and inverted
   task automatic t_plain(input logic inv);
      cfg_mod_en = 1'b0; cfg_invert = inv;
      for (int i = 0; i < 10; i++) begin
         tx_raw = logic'((i % 4) < 2);
         car_tick = logic'(i % 2);
         @(negedge clk);
         check(tx_raw ^ inv, inv ? "R2" : "R3", "unmodulated");
      end
      cfg_invert = 1'b0;
   endtask

   // R5/R6: zero bit carrier at a duty code and tick period
   task automatic t_duty(input logic [1:0] duty, input int per, input int n);
      int lo;
      lo = 8 >> duty;
      cfg_mod_en = 1'b1; cfg_invert = 1'b0; cfg_duty = duty;
      tx_raw = 1'b1; car_tick = 1'b1;
      @(negedge clk);
      check(1'b1, "R4", "one before zero bit");
      for (int k = 0; k < n; k++) begin
         tx_raw = 1'b0;
         car_tick = (per == 0) ? 1'b0 : logic'(k % per == per - 1);
         @(negedge clk);
         if (per == 0) check(1'b0, "R6", "no tick holds low phase");
         else check(((k / per) % 16 < lo) ? 1'b0 : 1'b1, "R5", $sformatf("duty %b per %0d k %0d", duty, per, k));
      end
      tx_raw = 1'b1; car_tick = 1'b0;
      @(negedge clk);
   endtask

   // R4: ones stay high under modulation
   task automatic t_ones();
      cfg_mod_en = 1'b1; cfg_duty = 2'b00; tx_raw = 1'b1;
      for (int i = 0; i < 20; i++) begin
         car_tick = logic'(i % 3 != 0);
         @(negedge clk);
         check(1'b1, "R4", "steady one");
      end
   endtask

   // R7: restart of carrier on each zero bit
   task automatic t_restart();
      cfg_mod_en = 1'b1; cfg_duty = 2'b11; car_tick = 1'b1;
      tx_raw = 1'b1;
      @(negedge clk);
      for (int b = 0; b < 2; b++) begin
         for (int k = 0; k < 6; k++) begin
            tx_raw = 1'b0;
            @(negedge clk);
            check((k == 0) ? 1'b0 : 1'b1, "R7", $sformatf("zero bit %0d cycle %0d", b, k));
         end
         tx_raw = 1'b1;
         @(negedge clk);
         check(1'b1, "R7", "gap high");
      end
      car_tick = 1'b0;
   endtask

   // R2: invert before modulation
   task automatic t_inv_mod();
      cfg_mod_en = 1'b1; cfg_invert = 1'b1; cfg_duty = 2'b01; car_tick = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tx_raw = 1'b0;
         @(negedge clk);
         check(1'b1, "R2", "raw zero inverted is steady");
      end
      for (int k = 0; k < 20; k++) begin
         tx_raw = 1'b1;
         @(negedge clk);
         check((k % 16 < 4) ? 1'b0 : 1'b1, "R2", $sformatf("raw one carried k %0d", k));
      end
      cfg_invert = 1'b0; tx_raw = 1'b1; car_tick = 1'b0;
      @(negedge clk);
   endtask

   // R8/R9: source selection with one-edge latency
   task automatic t_pinsel();
      logic [2:0] pat;
      cfg_mod_en = 1'b0; tx_raw = 1'b1;
      for (int i = 0; i < 16; i++) begin
         pat = 3'(i * 3 + 1);
         gpo_val = pat[0]; wpulse_in = pat[1]; rpulse_in = pat[2];
         cfg_pin_sel = 2'(i % 4);
         @(negedge clk);
         case (i % 4)
            0: check(1'b1, "R9", "sel 00 uart");
            1: check(gpo_val, "R8", "sel 01 gpo");
            2: check(wpulse_in, "R8", "sel 10 watt");
            default: check(rpulse_in, "R8", "sel 11 var");
         endcase
      end
      cfg_pin_sel = 2'b01; gpo_val = 1'b0;
      @(negedge clk);
      check(1'b0, "R9", "select change next edge");
      cfg_pin_sel = 2'b00;
      @(negedge clk);
      check(1'b1, "R9", "back to uart next edge");
   endtask

   initial begin
      t_reset();
      t_plain(1'b0);
      t_plain(1'b1);
      t_ones();
      for (int d = 0; d < 4; d++) t_duty(2'(d), 1, 40);
      t_duty(2'b01, 2, 40);
      t_duty(2'b10, 3, 40);
      t_duty(2'b00, 0, 12);
      t_restart();
      t_inv_mod();
      t_pinsel();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         vectors++; miscompares++;
         $display("FAIL watchdog: run hung, expected completion");
         report();
      end
   end
endmodule